// File: doc/BRIEF.md
# Adaptive Pruning Add-Compare-Select Stage

This block is one trellis step of an adaptive Viterbi decoder for a rate-1/2 convolutional code of constraint length 3, so the trellis has four states. The block keeps its own path metrics and a validity flag for each state. It accepts one received 2-bit symbol at a time. For each symbol it computes Hamming branch metrics and runs all four add-compare-select units in parallel. Only predecessors that are still alive take part. It then prunes the results against the smallest metric of the previous step plus a threshold.

The number of surviving states is capped by a configured limit. When too many states pass the threshold, the block does not sort them. Instead it lowers the working threshold by two and tests again, one clock per attempt. Symbol input is stalled until the result is committed. The threshold and the cap are sampled together with each symbol, and every symbol starts again from the configured threshold. The outputs are the new metrics, one survivor decision bit per state for a traceback unit, and the per-state validity flags.

Top module: `adaptive_acs_stage`

## Requirements
- R1: After reset, in_ready is 1 and out_valid is 0. Only state 0 is valid (valid_out = 4'b0001), with metric 0. Every other metric reads all ones (255), and dec_out is 0.
- R2: A state is s = {u(t-1), u(t-2)}. Input bit u moves s to {u, s[1]} and emits the expected symbol {u^s[1]^s[0], u^s[0]} as sym[1:0]. The branch metric is the Hamming distance between the expected symbol and sym.
- R3: The candidate metric of a state is the smaller of (predecessor metric + branch metric) over its valid predecessors. On a tie, the predecessor with the lower index wins. dec_out[s] is bit 0 of the winning predecessor, and is 0 for states that are not valid. Sums saturate at 255.
- R4: A state with no valid predecessor becomes invalid. Every invalid state reports metric 255.
- R5: A candidate survives only if its metric is strictly less than dm + Teff. Here dm is the minimum metric over the valid states before the step, and the sum is taken without wrap. A valid new metric is never below dm.
- R6: If more than nmax candidates survive, Teff drops by 2 (to 0 if it is below 2) and the test repeats on the next clock. The step commits when at most nmax survive, so valid_out never has more than nmax ones.
- R7: Teff is loaded from thr, and the cap from nmax, when each symbol is accepted. A reduction made during one symbol does not carry over to the next symbol.
- R8: in_ready is 1 exactly while no symbol is being evaluated. A symbol is taken when in_valid and in_ready are both 1. out_valid is a one-cycle pulse, 1 + (number of threshold reductions) cycles after acceptance. It comes together with the updated outputs.
- R9: While no symbol is accepted or evaluated, pm_out, valid_out and dec_out hold their values.
- R10: Once no state is valid, every later step leaves all states invalid until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A received symbol is offered |
| in_ready | output | 1 | The stage can take a symbol |
| sym | input | 2 | Received hard-decision symbol |
| thr | input | THW | Configured pruning threshold T |
| nmax | input | 3 | Survivor cap (1 to 4) |
| out_valid | output | 1 | One-cycle pulse: step committed |
| pm_out | output | 4*PMW | Path metrics, state s at bits [s*PMW +: PMW] |
| valid_out | output | 4 | Per-state survivor flags |
| dec_out | output | 4 | Per-state survivor decision bits |

## Verification
Corrupted metric or validity state is not hidden. It feeds the next step's minimum and threshold test, so a wrong value changes pm_out, valid_out or the number of reduction cycles at the very next out_valid pulse. It also keeps affecting every step after that. A wrong reduction step or a threshold that fails to reload shows first as a changed latency from acceptance to out_valid, and then as a different survivor set. The reference model is compared on every clock, so the first divergent cycle is the one reported.

// File: rtl/adaptive_acs_stage.sv
module adaptive_acs_stage #(
  parameter int PMW = 8,
  parameter int THW = 8,
  localparam int NS = 4,
  localparam int CW = $clog2(NS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        sym,
  input  logic [THW-1:0]    thr,
  input  logic [CW-1:0]     nmax,
  output logic              out_valid,
  output logic [NS*PMW-1:0] pm_out,
  output logic [NS-1:0]     valid_out,
  output logic [NS-1:0]     dec_out
);
  localparam int SW = ((PMW > THW) ? PMW : THW) + 1;
  localparam logic [PMW-1:0] PMAX = '1;

  logic           busy, ov_q;
  logic [1:0]     sym_q;
  logic [THW-1:0] thr_q, teff;
  logic [CW-1:0]  nmax_q;
  logic [PMW-1:0] pm_q [NS];
  logic [NS-1:0]  val_q, dec_q;

  logic [PMW-1:0] dm;
  logic [PMW-1:0] cand [NS];
  logic [NS-1:0]  cval, cdec, pass;
  logic [CW-1:0]  npass;
  logic           fits;

  function automatic logic [1:0] bm_of(input logic [1:0] ns, input logic x, input logic [1:0] r);
    logic [1:0] e;
    e = {ns[1] ^ ns[0] ^ x, ns[1] ^ x} ^ r;
    return {1'b0, e[1]} + {1'b0, e[0]};
  endfunction

  function automatic logic [PMW-1:0] sat_add(input logic [PMW-1:0] a, input logic [1:0] b);
    logic [PMW:0] s;
    s = {1'b0, a} + (PMW+1)'(b);
    return s[PMW] ? PMAX : s[PMW-1:0];
  endfunction

  always_comb begin
    dm = PMAX;
    for (int i = 0; i < NS; i++)
      if (val_q[i] && pm_q[i] < dm) dm = pm_q[i];
  end

  always_comb begin
    logic [PMW-1:0] m0, m1;
    for (int s = 0; s < NS; s++) begin
      m0 = sat_add(pm_q[2*(s%2)],   bm_of(2'(s), 1'b0, sym_q));
      m1 = sat_add(pm_q[2*(s%2)+1], bm_of(2'(s), 1'b1, sym_q));
      cval[s] = val_q[2*(s%2)] | val_q[2*(s%2)+1];
      cdec[s] = val_q[2*(s%2)+1] & (~val_q[2*(s%2)] | (m1 < m0));
      cand[s] = !cval[s] ? PMAX : (cdec[s] ? m1 : m0);
      pass[s] = cval[s] && (SW'(cand[s]) < SW'(dm) + SW'(teff));
    end
  end

  assign npass     = CW'($countones(pass));
  assign fits      = npass <= nmax_q;
  assign in_ready  = !busy;
  assign out_valid = ov_q;
  assign valid_out = val_q;
  assign dec_out   = dec_q;

  always_comb
    for (int i = 0; i < NS; i++) pm_out[i*PMW +: PMW] = pm_q[i];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      ov_q   <= 1'b0;
      sym_q  <= '0;
      thr_q  <= '0;
      teff   <= '0;
      nmax_q <= '0;
      val_q  <= NS'(1);
      dec_q  <= '0;
      for (int i = 0; i < NS; i++) pm_q[i] <= (i == 0) ? '0 : PMAX;
    end else begin
      ov_q <= 1'b0;
      if (!busy) begin
        if (in_valid) begin
          busy   <= 1'b1;
          sym_q  <= sym;
          thr_q  <= thr;
          teff   <= thr;
          nmax_q <= nmax;
        end
      end else if (fits) begin
        busy  <= 1'b0;
        ov_q  <= 1'b1;
        val_q <= pass;
        dec_q <= cdec & pass;
        for (int i = 0; i < NS; i++) pm_q[i] <= pass[i] ? cand[i] : PMAX;
      end else begin
        teff <= (teff >= THW'(2)) ? teff - THW'(2) : '0;
      end
    end
  end

  AST_SURV_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones(valid_out) <= int'(nmax_q)); // R6

  AST_OUT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> ($stable(pm_out) && $stable(valid_out) && $stable(dec_out) && !out_valid)); // R9

  for (genvar g = 0; g < NS; g++) begin : g_bound
    AST_PRUNE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && valid_out[g]) |->
        (pm_q[g] >= $past(dm)) && (SW'(pm_q[g]) < SW'($past(dm)) + SW'(thr_q))); // R5
    AST_DEAD_METRIC: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !valid_out[g]) |-> (pm_q[g] == PMAX) && !dec_out[g]); // R4
  end
endmodule

// File: tb/test_adaptive_acs_stage.sv
`timescale 1ns/1ps
module test_adaptive_acs_stage;
  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [1:0] sym = 0;
  logic [7:0] thr = 0;
  logic [2:0] nmax = 0;
  logic in_ready, out_valid;
  logic [31:0] pm_out;
  logic [3:0] valid_out, dec_out;

  adaptive_acs_stage i_adaptive_acs_stage (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .sym(sym), .thr(thr), .nmax(nmax), .out_valid(out_valid),
    .pm_out(pm_out), .valid_out(valid_out), .dec_out(dec_out));

  always #2.5 clk = ~clk;

  int ntest = 0, nfail = 0, cyc = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    ntest++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int mpm[4]; bit mval[4]; bit mdec[4];
  int tpm[4]; bit tval[4]; bit tdec[4]; int tcnt;
  bit mbusy, mov;
  int msym, mteff, mnmax;

  task automatic mstage(input int teff);
    int dm, p, u, ns, c0, c1, bm, m;
    bit have[4];
    dm = 255;
    for (int k = 0; k < 4; k++) begin
      if (mval[k] && mpm[k] < dm) dm = mpm[k];
      have[k] = 0; tpm[k] = 255; tdec[k] = 0;
    end
    for (p = 0; p < 4; p++) begin
      if (!mval[p]) continue;
      for (u = 0; u < 2; u++) begin
        ns = u * 2 + (p >> 1);
        c0 = u ^ ((p >> 1) & 1) ^ (p & 1);
        c1 = u ^ (p & 1);
        bm = (c0 != ((msym >> 1) & 1) ? 1 : 0) + (c1 != (msym & 1) ? 1 : 0);
        m = mpm[p] + bm;
        if (m > 255) m = 255;
        if (!have[ns] || m < tpm[ns]) begin
          tpm[ns] = m; have[ns] = 1; tdec[ns] = bit'(p & 1);
        end
      end
    end
    tcnt = 0;
    for (int k = 0; k < 4; k++) begin
      tval[k] = have[k] && (tpm[k] < dm + teff);
      if (tval[k]) tcnt++;
      else begin tpm[k] = 255; tdec[k] = 0; end
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      mbusy = 0; mov = 0;
      for (int k = 0; k < 4; k++) begin
        mpm[k] = (k == 0) ? 0 : 255; mval[k] = (k == 0); mdec[k] = 0;
      end
    end else begin
      mov = 0;
      if (!mbusy) begin
        if (in_valid) begin
          mbusy = 1; msym = sym; mteff = thr; mnmax = nmax;
        end
      end else begin
        mstage(mteff);
        if (tcnt <= mnmax) begin
          for (int k = 0; k < 4; k++) begin
            mpm[k] = tpm[k]; mval[k] = tval[k]; mdec[k] = tdec[k];
          end
          mbusy = 0; mov = 1;
        end else mteff = (mteff >= 2) ? mteff - 2 : 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(in_ready == !mbusy, "R8 in_ready", in_ready, !mbusy);
      chk(out_valid == mov, "R8 out_valid", out_valid, mov);
      for (int k = 0; k < 4; k++) begin
        chk(pm_out[k*8 +: 8] == mpm[k], mov ? "R5 metric" : "R9 metric", pm_out[k*8 +: 8], mpm[k]);
        chk(valid_out[k] == mval[k], "R6 valid", valid_out[k], mval[k]);
        chk(dec_out[k] == mdec[k], "R3 decision", dec_out[k], mdec[k]);
      end
    end
  end

  task automatic do_reset();
    rst_n = 0; in_valid = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic send(input logic [1:0] s, input int t, input int n);
    while (!in_ready) @(negedge clk);
    sym = s; thr = 8'(t); nmax = 3'(n); in_valid = 1;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic wait_out(output int lat);
    lat = 0;
    while (!out_valid) begin @(negedge clk); lat++; end
  endtask

  int lat, es, u, c;
  logic [3:0] held;

  initial begin
    do_reset();
    // R1
    chk(in_ready == 1, "R1 ready", in_ready, 1);
    chk(out_valid == 0, "R1 out_valid", out_valid, 0);
    chk(valid_out == 4'b0001, "R1 valid", valid_out, 1);
    chk(pm_out == 32'hFFFF_FF00, "R1 metrics", pm_out, 32'hFFFF_FF00);
    chk(dec_out == 0, "R1 decisions", dec_out, 0);

    // R2 / R3 / R4: first step from state 0
    send(2'b00, 8, 4); wait_out(lat);
    chk(lat == 1, "R8 latency", lat, 1);
    chk(pm_out == 32'hFF02_FF00, "R2 metrics", pm_out, 32'hFF02_FF00);
    chk(valid_out == 4'b0101, "R4 valid", valid_out, 5);

    // R6: three reductions 8->6->4->2
    send(2'b00, 8, 1); wait_out(lat);
    chk(lat == 4, "R6 latency", lat, 4);
    chk(valid_out == 4'b0001, "R6 valid", valid_out, 1);

    // R7: threshold reloaded at full value
    send(2'b00, 8, 4); wait_out(lat);
    chk(lat == 1, "R7 latency", lat, 1);
    chk(valid_out == 4'b0101, "R7 valid", valid_out, 5);

    // R9: idle hold
    held = valid_out;
    repeat (6) @(negedge clk);
    chk(valid_out == held, "R9 hold", valid_out, held);

    // R10: zero threshold kills all, stays dead
    send(2'b01, 0, 4); wait_out(lat);
    chk(valid_out == 0, "R10 dead", valid_out, 0);
    send(2'b00, 8, 4); wait_out(lat);
    chk(valid_out == 0, "R10 stays dead", valid_out, 0);
    chk(pm_out == 32'hFFFF_FFFF, "R4 dead metrics", pm_out, 32'hFFFF_FFFF);

    // Encoded stream with errors, varied T and cap
    do_reset();
    es = 0;
    for (int i = 0; i < 400; i++) begin
      u = $urandom % 2;
      c = ((u ^ (es >> 1) ^ es) & 1) * 2 + ((u ^ es) & 1);
      es = u * 2 + (es >> 1);
      if ($urandom % 10 == 0) c ^= (1 << ($urandom % 2));
      send(2'(c), 2 + $urandom % 9, 1 + $urandom % 4);
    end

    // Pure noise: metrics climb to saturation (R3)
    do_reset();
    for (int i = 0; i < 900; i++) send(2'($urandom % 4), 8, 4);
    wait_out(lat);
    repeat (3) @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end

  initial begin
    wait (cyc >= 150000);
    nfail++; ntest++;
    $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
    $display("  [TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end
endmodule